// File: doc/BRIEF.md
# Code-Memory Programming and Lock Controller

This block is the programming-side controller of a small on-chip code store. A programmer presents a mode, a byte address and a data byte together with a single-cycle command strobe. The block writes single bytes, reads them back for verification, erases the whole array, programs protection bits one at a time, and returns fixed identification bytes. Writes are self-timed. A busy output covers the whole write window. During that window a verify read returns a polling byte, so the end of the write can be found without a timer on the host side.

Three lock bits are always programmed in order. They give four protection levels. With no bits set the block is unrestricted. From one bit upward, array programming is refused and table reads issued from external code may not reach the internal bytes. From two bits upward, verify reads are refused too. With all three bits set, execution from external memory is also blocked. The two fetch permissions are plain outputs for the fetch logic. A chip erase fills the array with FFh and clears every lock bit.

The command input is a strobe with no ready. There is no back-pressure: a write-type command that arrives while busy is dropped and reported on the error pulse. A read response is a one-cycle valid pulse that the consumer must take when it appears.

Top module: `flash_prog_ctrl`

## Requirements
- R1: A chip erase (mode 2) is accepted at any lock level when idle. It holds busy high for exactly DEPTH cycles. Afterwards every byte reads FFh and lock_level is 0.
- R2: A byte program (mode 0) is accepted on one strobe. Busy goes high at the next clock edge and stays high for exactly WRITE_CYCLES cycles. After that, a verify returns the written byte without any further strobe.
- R3: A program strobe aimed at a byte that does not read FFh is refused. The refusal gives an error pulse and the byte keeps its value.
- R4: Each accepted lock strobe (mode 3) raises lock_level by exactly 1 once its write window ends. A lock strobe when lock_level is 3 is refused with an error pulse.
- R5: While lock_level is 1 or more, byte program strobes are refused with an error pulse and ext_table_ok is low. ext_table_ok is high only at lock_level 0.
- R6: While lock_level is 2 or more, verify strobes (mode 1) produce no response and an error pulse.
- R7: ext_exec_ok is low exactly when lock_level is 3.
- R8: A signature read (mode 4) returns 1Eh at address 030h and 51h at 031h. At 032h it returns FFh, or 05h when SIG_LOW_VOLT is 1. Every other address returns FFh. Signature reads are allowed at every lock level and while busy.
- R9: A verify strobe taken while busy returns a polling byte: bit 7 is the complement of bit 7 of the byte being written (FFh for erase and lock writes), and bits 6..0 are zero.
- R10: A program, erase or lock strobe that arrives while busy is ignored and gives an error pulse. It does not change the array.
- R11: Modes are encoded as 0 program, 1 verify, 2 erase, 3 lock, 4 signature. Modes 5 to 7 give an error pulse. A read response (rsp_valid with rsp_data) and an error pulse each appear for one cycle, in the cycle after the strobe.
- R12: After reset, busy, rsp_valid and err_pulse are low, lock_level is 0, and ext_table_ok and ext_exec_ok are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_mode | input | 3 | Command mode (see R11) |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | 8 | Data byte for program |
| rsp_valid | output | 1 | Read response valid, one cycle |
| rsp_data | output | 8 | Read response byte |
| busy | output | 1 | Self-timed write in progress |
| err_pulse | output | 1 | One-cycle pulse for a refused or ignored command |
| lock_level | output | 2 | Number of lock bits programmed |
| ext_table_ok | output | 1 | Table reads from external code may reach internal bytes |
| ext_exec_ok | output | 1 | Execution from external memory allowed |

## Verification
A vector table first runs erase, program, verify and signature sequences. It then programs blank bytes, re-programs a non-blank byte, and sends an unknown mode; comparing read-back values shows whether a refused program left the byte alone. The same read patterns are repeated after one, two and three lock bits. This separates the program refusal at level 1 from the verify refusal at level 2, and it shows that the fourth lock strobe is refused. Directed sequences measure the busy width of program and erase writes. They also place a verify and a program strobe inside a running write, to separate polling data from real data and to show that a strobe during busy is dropped.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [2:0] {
    MODE_PROG   = 3'd0,
    MODE_VERIFY = 3'd1,
    MODE_ERASE  = 3'd2,
    MODE_LOCK   = 3'd3,
    MODE_SIG    = 3'd4
  } fmode_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_LOCK  = 2'd3
  } wop_e;

  localparam logic [7:0] BLANK_BYTE = 8'hFF;
  localparam logic [1:0] LOCK_FULL  = 2'd3;

endpackage

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  // Non-volatile contents: deliberately not reset
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate
  import flash_prog_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [2:0] cmd_mode,
  input  logic       busy,
  input  logic [1:0] lock_cnt,
  input  logic       target_blank,
  output wop_e       start_op,
  output logic       read_verify,
  output logic       read_sig,
  output logic       reject
);
  always_comb begin
    start_op    = OP_NONE;
    read_verify = 1'b0;
    read_sig    = 1'b0;
    reject      = 1'b0;
    if (cmd_valid) begin
      case (cmd_mode)
        MODE_PROG:
          if (!busy && lock_cnt == 2'd0 && target_blank) start_op = OP_PROG;
          else reject = 1'b1;
        MODE_ERASE:
          if (!busy) start_op = OP_ERASE;
          else reject = 1'b1;
        MODE_LOCK:
          if (!busy && lock_cnt != LOCK_FULL) start_op = OP_LOCK;
          else reject = 1'b1;
        MODE_VERIFY:
          if (lock_cnt < 2'd2) read_verify = 1'b1;
          else reject = 1'b1;
        MODE_SIG:
          read_sig = 1'b1;
        default:
          reject = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/flash_write_seq.sv
module flash_write_seq
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int WRITE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wop_e              start_op,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [7:0]        start_data,
  output logic              busy,
  output logic [7:0]        pend_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              lock_done,
  output logic              erase_done
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAX_D = (DEPTH > WRITE_CYCLES) ? DEPTH : WRITE_CYCLES;
  localparam int CNT_W = $clog2(MAX_D) + 1;
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(WRITE_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(DEPTH - 1);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  wop_e              op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        op_q   <= OP_NONE;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (start_op != OP_NONE) begin
      busy_q <= 1'b1;
      op_q   <= start_op;
      cnt_q  <= (start_op == OP_ERASE) ? ERASE_LAST : PROG_LAST;
      addr_q <= start_addr;
      data_q <= (start_op == OP_PROG) ? start_data : BLANK_BYTE;
    end
  end

  assign finish     = busy_q && (cnt_q == '0);
  // Erase sweeps one byte per cycle using the window counter as address
  assign wr_en      = busy_q && ((op_q == OP_ERASE) || (op_q == OP_PROG && finish));
  assign wr_addr    = (op_q == OP_ERASE) ? cnt_q[ADDR_W-1:0] : addr_q;
  assign wr_data    = data_q;
  assign lock_done  = finish && (op_q == OP_LOCK);
  assign erase_done = finish && (op_q == OP_ERASE);
  assign busy       = busy_q;
  assign pend_data  = data_q;
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int WRITE_CYCLES = 16,
  parameter bit SIG_LOW_VOLT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_mode,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              busy,
  output logic              err_pulse,
  output logic [1:0]        lock_level,
  output logic              ext_table_ok,
  output logic              ext_exec_ok
);
  localparam logic [7:0] SIG_VARIANT = SIG_LOW_VOLT ? 8'h05 : 8'hFF;

  wop_e              start_op;
  logic              read_verify, read_sig, reject;
  logic [7:0]        rd_data, pend_data, wr_data;
  logic [ADDR_W-1:0] wr_addr;
  logic              wr_en, lock_done, erase_done, busy_w;
  logic [1:0]        lock_cnt;
  logic              rsp_valid_q, err_q;
  logic [7:0]        rsp_data_q, sig_byte;

  flash_byte_array #(.ADDR_W(ADDR_W)) array_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(cmd_addr), .rd_data(rd_data)
  );

  flash_cmd_gate gate_i (
    .cmd_valid(cmd_valid), .cmd_mode(cmd_mode), .busy(busy_w),
    .lock_cnt(lock_cnt), .target_blank(rd_data == BLANK_BYTE),
    .start_op(start_op), .read_verify(read_verify), .read_sig(read_sig),
    .reject(reject)
  );

  flash_write_seq #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_op(start_op), .start_addr(cmd_addr),
    .start_data(cmd_wdata), .busy(busy_w), .pend_data(pend_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lock_done(lock_done), .erase_done(erase_done)
  );

  always_comb begin
    case (cmd_addr)
      ADDR_W'(12'h030): sig_byte = 8'h1E;
      ADDR_W'(12'h031): sig_byte = 8'h51;
      ADDR_W'(12'h032): sig_byte = SIG_VARIANT;
      default:          sig_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_cnt    <= 2'd0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= 8'h00;
      err_q       <= 1'b0;
    end else begin
      if (erase_done)     lock_cnt <= 2'd0;
      else if (lock_done) lock_cnt <= lock_cnt + 2'd1;
      err_q       <= reject;
      rsp_valid_q <= read_verify | read_sig;
      if (read_sig)
        rsp_data_q <= sig_byte;
      else if (read_verify)
        rsp_data_q <= busy_w ? {~pend_data[7], 7'b0} : rd_data;
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_data     = rsp_data_q;
  assign err_pulse    = err_q;
  assign busy         = busy_w;
  assign lock_level   = lock_cnt;
  assign ext_table_ok = (lock_cnt == 2'd0);
  assign ext_exec_ok  = (lock_cnt != LOCK_FULL);
endmodule

// File: rtl/flash_prog_ctrl_chk.sv
module flash_prog_ctrl_chk #(
  parameter int ADDR_W       = 12,
  parameter int WRITE_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_mode,
  input logic       rsp_valid,
  input logic       err_pulse,
  input logic       busy,
  input logic [1:0] lock_level,
  input logic       ext_exec_ok
);
  localparam int DEPTH = 1 << ADDR_W;

  int unsigned run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 0;
    else        run_q <= busy ? run_q + 1 : 0;
  end

  // R1 R2
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == WRITE_CYCLES || run_q == DEPTH));

  // R10
  busy_strobe_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && (cmd_mode == 3'd0 || cmd_mode == 3'd2 || cmd_mode == 3'd3))
    |=> err_pulse);

  // R4
  lock_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_level != $past(lock_level)) |->
    (lock_level == $past(lock_level) + 2'd1 || lock_level == 2'd0));

  // R5
  locked_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode == 3'd0 && lock_level != 2'd0) |=> err_pulse);

  // R6
  locked_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode == 3'd1 && lock_level >= 2'd2) |=> (err_pulse && !rsp_valid));

  // R7
  exec_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_exec_ok |-> lock_level == 2'd3);

  // R11
  rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid));
endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(
  .ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
  .rsp_valid(rsp_valid), .err_pulse(err_pulse), .busy(busy),
  .lock_level(lock_level), .ext_exec_ok(ext_exec_ok)
);

// File: tb/flash_prog_ctrl_tb.sv
`timescale 1ns/1ps
module flash_prog_ctrl_tb_top;
  localparam int ADDR_W = 12;
  localparam int WC     = 16;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [2:0]        cmd_mode = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [7:0]        cmd_wdata = '0;
  logic              rsp_valid, busy, err_pulse, ext_table_ok, ext_exec_ok;
  logic [7:0]        rsp_data;
  logic [1:0]        lock_level;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  flash_prog_ctrl #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WC), .SIG_LOW_VOLT(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .busy(busy), .err_pulse(err_pulse),
    .lock_level(lock_level), .ext_table_ok(ext_table_ok), .ext_exec_ok(ext_exec_ok)
  );

  // {req[4], mode[3], addr[12], data[8], exp_err, exp_rsp, exp_data[8]}
  localparam int NV = 24;
  localparam logic [36:0] VEC [NV] = '{
    {4'd1,  3'd2, 12'h000, 8'h00, 1'b0, 1'b0, 8'h00}, // R1 erase
    {4'd1,  3'd1, 12'h005, 8'h00, 1'b0, 1'b1, 8'hFF}, // R1 blank
    {4'd2,  3'd0, 12'h005, 8'hA5, 1'b0, 1'b0, 8'h00}, // R2 program
    {4'd2,  3'd1, 12'h005, 8'h00, 1'b0, 1'b1, 8'hA5},
    {4'd3,  3'd0, 12'h005, 8'h00, 1'b1, 1'b0, 8'h00}, // R3 non-blank
    {4'd3,  3'd1, 12'h005, 8'h00, 1'b0, 1'b1, 8'hA5},
    {4'd2,  3'd0, 12'hFFF, 8'h3C, 1'b0, 1'b0, 8'h00},
    {4'd2,  3'd1, 12'hFFF, 8'h00, 1'b0, 1'b1, 8'h3C},
    {4'd8,  3'd4, 12'h030, 8'h00, 1'b0, 1'b1, 8'h1E}, // R8 signature
    {4'd8,  3'd4, 12'h031, 8'h00, 1'b0, 1'b1, 8'h51},
    {4'd8,  3'd4, 12'h032, 8'h00, 1'b0, 1'b1, 8'hFF},
    {4'd8,  3'd4, 12'h040, 8'h00, 1'b0, 1'b1, 8'hFF},
    {4'd11, 3'd7, 12'h000, 8'h00, 1'b1, 1'b0, 8'h00}, // R11 unknown mode
    {4'd4,  3'd3, 12'h000, 8'h00, 1'b0, 1'b0, 8'h00}, // R4 lock 1
    {4'd5,  3'd0, 12'h010, 8'h11, 1'b1, 1'b0, 8'h00}, // R5 prog refused
    {4'd5,  3'd1, 12'h010, 8'h00, 1'b0, 1'b1, 8'hFF},
    {4'd4,  3'd3, 12'h000, 8'h00, 1'b0, 1'b0, 8'h00}, // R4 lock 2
    {4'd6,  3'd1, 12'h005, 8'h00, 1'b1, 1'b0, 8'h00}, // R6 verify refused
    {4'd8,  3'd4, 12'h031, 8'h00, 1'b0, 1'b1, 8'h51},
    {4'd4,  3'd3, 12'h000, 8'h00, 1'b0, 1'b0, 8'h00}, // R4 lock 3
    {4'd4,  3'd3, 12'h000, 8'h00, 1'b1, 1'b0, 8'h00}, // R4 fourth refused
    {4'd1,  3'd2, 12'h000, 8'h00, 1'b0, 1'b0, 8'h00}, // R1 erase clears
    {4'd1,  3'd1, 12'h005, 8'h00, 1'b0, 1'b1, 8'hFF},
    {4'd1,  3'd1, 12'hFFF, 8'h00, 1'b0, 1'b1, 8'hFF}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [2:0] m, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_mode = m; cmd_addr = a; cmd_wdata = d;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic run_vec(input logic [36:0] v);
    string rq;
    rq = $sformatf("R%0d", v[36:33]);
    @(negedge clk);
    strobe(v[32:30], v[29:18], v[17:10]);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(err_pulse == v[9], rq, err_pulse, v[9]);
    chk(rsp_valid == v[8], rq, rsp_valid, v[8]);
    if (v[8]) begin
      chk(rsp_data == v[7:0], rq, rsp_data, v[7:0]);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R11 one-cycle rsp", rsp_valid, 0);
    end
    wait_idle();
  endtask

  task automatic read_one(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string rq);
    @(negedge clk); strobe(3'd1, a, 8'h00);
    @(negedge clk); cmd_valid = 1'b0;
    chk(rsp_valid && rsp_data == exp, rq, rsp_data, exp);
  endtask

  task automatic count_busy(input logic [2:0] m, input logic [ADDR_W-1:0] a,
                            input logic [7:0] d, input int exp, input string rq);
    int cyc;
    @(negedge clk); strobe(m, a, d);
    cyc = 0;
    forever begin
      @(negedge clk); cmd_valid = 1'b0;
      if (!busy) break;
      cyc++;
    end
    chk(cyc == exp, rq, cyc, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int cyc;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !rsp_valid && !err_pulse, "R12 idle outputs", {busy, rsp_valid, err_pulse}, 0);
    chk(lock_level == 2'd0 && ext_table_ok && ext_exec_ok, "R12 lock outputs",
        {lock_level, ext_table_ok, ext_exec_ok}, 3);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    chk(lock_level == 2'd0, "R1 locks cleared", lock_level, 0);

    // R1 erase busy window
    count_busy(3'd2, '0, 8'h00, DEPTH, "R1 erase busy");

    // R2 program window with R9 polling and R10 busy strobe inside it
    @(negedge clk); strobe(3'd0, 12'h100, 8'h5A);
    cyc = 0;
    forever begin
      @(negedge clk); cmd_valid = 1'b0;
      if (!busy) break;
      cyc++;
      if (cyc == 1) strobe(3'd1, 12'h100, 8'h00);
      if (cyc == 2) begin
        chk(rsp_valid && rsp_data == 8'h80, "R9 polling", rsp_data, 8'h80);
        strobe(3'd0, 12'h200, 8'hAA);
      end
      if (cyc == 3) chk(err_pulse == 1'b1, "R10 busy strobe err", err_pulse, 1);
    end
    chk(cyc == WC, "R2 program busy", cyc, WC);
    read_one(12'h100, 8'h5A, "R2 data after write");
    read_one(12'h200, 8'hFF, "R10 dropped write");

    // R5 R7 lock progression at the ports
    count_busy(3'd3, '0, 8'h00, WC, "R4 lock busy");
    chk(lock_level == 2'd1 && !ext_table_ok && ext_exec_ok, "R5 level one",
        {lock_level, ext_table_ok, ext_exec_ok}, 3'b010 << 1 | 1);
    count_busy(3'd3, '0, 8'h00, WC, "R4 lock busy");
    chk(lock_level == 2'd2 && ext_exec_ok, "R4 level two", lock_level, 2);
    count_busy(3'd3, '0, 8'h00, WC, "R4 lock busy");
    chk(lock_level == 2'd3 && !ext_exec_ok && !ext_table_ok, "R7 exec blocked",
        {lock_level, ext_exec_ok}, 3'b110);
    count_busy(3'd2, '0, 8'h00, DEPTH, "R1 erase busy");
    chk(lock_level == 2'd0 && ext_exec_ok && ext_table_ok, "R1 erase unlocks",
        {lock_level, ext_exec_ok, ext_table_ok}, 3);
    read_one(12'h100, 8'hFF, "R1 erased byte");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule